// File: doc/BRIEF.md
# Lookup Miss Redirect Controller

This controller sits after the local forwarding lookup on an ingress path. Each packet descriptor arrives together with a hit flag and a local result. On a hit, the descriptor leaves straight away with its local result. On a miss, the descriptor is parked under a small tag and sent out on a redirect port toward one of two full-table resolvers. When both resolvers are available, successive misses take turns between the primary and the backup resolver. When only one is available, every miss goes to that one.

A resolver answers with a reply header and then a group of related table entries. The header carries the tag, the resolved result and how many entries follow. Accepting the header releases the parked descriptor with the resolved result. The entries that follow are passed one per cycle to a table-install port. Replies may come back in any order.

The block also counts accepted misses over fixed windows of clock cycles. Inside a window, the miss that pushes the count above a configured limit raises a one-cycle request for a full table download.

Top module: `miss_redirect_ctrl`

## Requirements
- R1: Once reset is released, `out_valid`, `rd_valid`, `inst_valid` and `dl_req` are low, and both `in_ready` and `rsp_ready` are high.
- R2: A descriptor accepted with `in_hit`=1 appears on `out_valid`/`out_desc`/`out_result` one cycle later, carrying its local result. No redirect is issued for it.
- R3: A descriptor accepted with `in_hit`=0 appears on `rd_valid`/`rd_desc` one cycle later. Its `rd_tag` is the lowest-numbered tag not currently outstanding.
- R4: While `pri_up` and `bak_up` are both 1, successive misses alternate between resolvers. The first miss after reset goes to the primary (`rd_backup`=0), the next to the backup (`rd_backup`=1), and so on.
- R5: When all NTAG tags are outstanding, `in_ready` is 0 for a miss (`in_hit`=0) and stays 1 for a hit.
- R6: Accepting a reply header (`rsp_valid`&`rsp_ready`) releases the descriptor parked under `rsp_tag`. It appears on `out_valid` one cycle later with `rsp_result`, whatever order the replies arrive in, and the tag becomes free again.
- R7: A header with `rsp_count`=K>0 makes the next K `ent_valid` beats appear, one cycle later each, on `inst_valid`/`inst_data`. `rsp_ready` stays 0 until the last of those K beats has been taken.
- R8: A header with `rsp_count`=0 still releases its descriptor and causes no install write.
- R9: If only `pri_up` is 1, every miss is sent with `rd_backup`=0. If only `bak_up` is 1, every miss is sent with `rd_backup`=1.
- R10: An `ent_valid` beat that arrives while no entry group is pending is ignored, and `inst_valid` stays 0.
- R11: In a window, the accepted miss that makes the window's count equal to `miss_limit`+1 raises `dl_req` for exactly one cycle, one cycle after that miss is accepted.
- R12: The miss count restarts at every window boundary. Window k covers the cycles k·WIN to k·WIN+WIN-1 counted from the first clock edge after reset, so misses in an earlier window never add to a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup result with descriptor is present |
| in_ready | output | 1 | Block can take the present lookup result |
| in_hit | input | 1 | Local lookup hit |
| in_desc | input | DW | Packet descriptor |
| in_result | input | RW | Local forwarding result |
| pri_up | input | 1 | Primary resolver available |
| bak_up | input | 1 | Backup resolver available |
| rd_valid | output | 1 | Redirect request valid |
| rd_backup | output | 1 | Redirect goes to the backup resolver |
| rd_tag | output | TW | Tag of the parked descriptor |
| rd_desc | output | DW | Descriptor sent for resolution |
| rsp_valid | input | 1 | Reply header present |
| rsp_ready | output | 1 | Block can take a reply header |
| rsp_tag | input | TW | Tag the reply answers |
| rsp_result | input | RW | Resolved forwarding result |
| rsp_count | input | CW | Number of related entries that follow |
| ent_valid | input | 1 | Related entry beat present |
| ent_data | input | EW | Related entry |
| inst_valid | output | 1 | Table install write |
| inst_data | output | EW | Entry to install |
| out_valid | output | 1 | Descriptor forwarded |
| out_desc | output | DW | Forwarded descriptor |
| out_result | output | RW | Result used to forward it |
| miss_limit | input | LW | Misses allowed per window before a download request |
| dl_req | output | 1 | One-cycle full table download request |

## Verification
Every result of this block comes from a register one edge after the triggering input is accepted. This covers the forwarded descriptor, the redirect, each install write and the download pulse. The bench drives inputs after a falling edge and samples results at the next falling edge, so exactly one rising edge separates the stimulus from its check. `in_ready` is the only combinational output; it is checked a moment after the inputs change, before any edge. The window tests use the bench's own count of rising edges since reset to place misses at chosen offsets inside a window.

// File: rtl/miss_redirect_ctrl.sv
module miss_redirect_ctrl #(
  parameter int DW   = 32,
  parameter int RW   = 16,
  parameter int EW   = 48,
  parameter int NTAG = 4,
  parameter int MAXE = 8,
  parameter int WIN  = 64,
  parameter int LW   = 8,
  localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1,
  localparam int CW  = $clog2(MAXE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_hit,
  input  logic [DW-1:0] in_desc,
  input  logic [RW-1:0] in_result,
  input  logic          pri_up,
  input  logic          bak_up,
  output logic          rd_valid,
  output logic          rd_backup,
  output logic [TW-1:0] rd_tag,
  output logic [DW-1:0] rd_desc,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [TW-1:0] rsp_tag,
  input  logic [RW-1:0] rsp_result,
  input  logic [CW-1:0] rsp_count,
  input  logic          ent_valid,
  input  logic [EW-1:0] ent_data,
  output logic          inst_valid,
  output logic [EW-1:0] inst_data,
  output logic          out_valid,
  output logic [DW-1:0] out_desc,
  output logic [RW-1:0] out_result,
  input  logic [LW-1:0] miss_limit,
  output logic          dl_req
);

  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int MW = LW + 1;

  logic [NTAG-1:0] busy;
  logic [DW-1:0]   held [NTAG];
  logic            have_free;
  logic [TW-1:0]   free_tag;
  logic            streaming;
  logic [CW-1:0]   remain;
  logic            turn;
  logic [WW-1:0]   win_cnt;
  logic [MW-1:0]   miss_cnt, miss_base, miss_nxt;

  always_comb begin
    have_free = 1'b0;
    free_tag  = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        have_free = 1'b1;
        free_tag  = TW'(i);
      end
    end
  end

  wire rsp_fire  = rsp_valid && rsp_ready;
  wire in_fire   = in_valid && in_ready;
  wire miss_fire = in_fire && !in_hit;
  wire hit_fire  = in_fire && in_hit;
  wire to_bak    = bak_up && (!pri_up || turn);

  assign rsp_ready = !streaming;
  assign in_ready  = !rsp_fire && (in_hit || have_free);

  assign miss_base = (win_cnt == '0) ? '0 : miss_cnt;
  assign miss_nxt  = (miss_base == '1) ? miss_base : miss_base + MW'(miss_fire);

  always_ff @(posedge clk) begin
    if (miss_fire) held[free_tag] <= in_desc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= '0;
      turn       <= 1'b0;
      streaming  <= 1'b0;
      remain     <= '0;
      rd_valid   <= 1'b0;
      rd_backup  <= 1'b0;
      rd_tag     <= '0;
      rd_desc    <= '0;
      out_valid  <= 1'b0;
      out_desc   <= '0;
      out_result <= '0;
      inst_valid <= 1'b0;
      inst_data  <= '0;
      win_cnt    <= '0;
      miss_cnt   <= '0;
      dl_req     <= 1'b0;
    end else begin
      if (miss_fire) busy[free_tag] <= 1'b1;
      if (rsp_fire)  busy[rsp_tag]  <= 1'b0;
      if (miss_fire && pri_up && bak_up) turn <= ~turn;

      rd_valid <= miss_fire;
      if (miss_fire) begin
        rd_backup <= to_bak;
        rd_tag    <= free_tag;
        rd_desc   <= in_desc;
      end

      out_valid <= rsp_fire || hit_fire;
      if (rsp_fire) begin
        out_desc   <= held[rsp_tag];
        out_result <= rsp_result;
      end else if (hit_fire) begin
        out_desc   <= in_desc;
        out_result <= in_result;
      end

      if (rsp_fire) begin
        streaming <= (rsp_count != '0);
        remain    <= rsp_count;
      end else if (streaming && ent_valid) begin
        remain <= remain - CW'(1);
        if (remain == CW'(1)) streaming <= 1'b0;
      end
      inst_valid <= streaming && ent_valid;
      if (streaming && ent_valid) inst_data <= ent_data;

      win_cnt  <= (win_cnt == WW'(WIN - 1)) ? '0 : win_cnt + WW'(1);
      miss_cnt <= miss_nxt;
      dl_req   <= miss_fire && (miss_nxt == ({1'b0, miss_limit} + MW'(1)));
    end
  end

endmodule

module miss_redirect_ctrl_chk #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_hit,
  input logic [DW-1:0] in_desc,
  input logic          pri_up,
  input logic          bak_up,
  input logic          rd_valid,
  input logic [DW-1:0] rd_desc,
  input logic          rd_backup,
  input logic          out_valid,
  input logic [DW-1:0] out_desc,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [CW-1:0] rsp_count,
  input logic          inst_valid,
  input logic          ent_valid,
  input logic          dl_req
);

  assert_hit_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_hit |=> out_valid && !rd_valid && out_desc == $past(in_desc));

  assert_miss_redirects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_hit |=> rd_valid && rd_desc == $past(in_desc));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> out_valid);

  assert_empty_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_count == '0 |=> !inst_valid);

  assert_primary_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_hit && pri_up && !bak_up |=> !rd_backup);

  assert_backup_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_hit && !pri_up && bak_up |=> rd_backup);

  assert_install_needs_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid |-> $past(ent_valid));

  assert_dl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dl_req |=> !dl_req);

endmodule

bind miss_redirect_ctrl miss_redirect_ctrl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_hit(in_hit), .in_desc(in_desc), .pri_up(pri_up), .bak_up(bak_up),
  .rd_valid(rd_valid), .rd_desc(rd_desc), .rd_backup(rd_backup),
  .out_valid(out_valid), .out_desc(out_desc), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_count(rsp_count), .inst_valid(inst_valid),
  .ent_valid(ent_valid), .dl_req(dl_req)
);

// File: tb/test_miss_redirect_ctrl.sv
`timescale 1ns/1ps
module test_miss_redirect_ctrl;
  localparam int DW = 32, RW = 16, EW = 48, WIN = 64, LW = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_hit = 0, pri_up = 1, bak_up = 1;
  logic [DW-1:0] in_desc = '0;
  logic [RW-1:0] in_result = '0;
  logic rsp_valid = 0, ent_valid = 0;
  logic [1:0] rsp_tag = '0;
  logic [RW-1:0] rsp_result = '0;
  logic [3:0] rsp_count = '0;
  logic [EW-1:0] ent_data = '0;
  logic [LW-1:0] miss_limit = 8'hFF;
  logic in_ready, rd_valid, rd_backup, rsp_ready, inst_valid, out_valid, dl_req;
  logic [1:0] rd_tag;
  logic [DW-1:0] rd_desc, out_desc;
  logic [EW-1:0] inst_data;
  logic [RW-1:0] out_result;

  int checks = 0, errors = 0, bcyc = 0;
  bit done = 0;
  logic [DW-1:0] parked [4];

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) bcyc <= bcyc + 1;

  miss_redirect_ctrl i_miss_redirect_ctrl (
    .clk, .rst_n, .in_valid, .in_ready, .in_hit, .in_desc, .in_result,
    .pri_up, .bak_up, .rd_valid, .rd_backup, .rd_tag, .rd_desc,
    .rsp_valid, .rsp_ready, .rsp_tag, .rsp_result, .rsp_count,
    .ent_valid, .ent_data, .inst_valid, .inst_data,
    .out_valid, .out_desc, .out_result, .miss_limit, .dl_req
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send_hit(input logic [DW-1:0] d, input logic [RW-1:0] r);
    in_valid = 1; in_hit = 1; in_desc = d; in_result = r;
    @(negedge clk);
    in_valid = 0;
    check(out_valid && out_desc == d && out_result == r, "R2 hit forward", out_desc, d);
    check(!rd_valid, "R2 no redirect on hit", rd_valid, 0);
  endtask

  task automatic send_miss(input logic [DW-1:0] d, input int tag, input bit bak, input bit dl);
    in_valid = 1; in_hit = 0; in_desc = d;
    #1 check(in_ready, "R5 ready with free tag", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    parked[tag] = d;
    check(rd_valid && rd_desc == d && !out_valid, "R3 redirect", rd_desc, d);
    check(rd_tag == 2'(tag), "R3 lowest free tag", rd_tag, tag);
    check(rd_backup == bak, "R4/R9 resolver choice", rd_backup, bak);
    check(dl_req == dl, "R11 download request", dl_req, dl);
  endtask

  task automatic send_rsp(input int tag, input logic [RW-1:0] r, input int cnt, input logic [EW-1:0] base);
    check(rsp_ready, "R7 header ready when idle", rsp_ready, 1);
    rsp_valid = 1; rsp_tag = 2'(tag); rsp_result = r; rsp_count = 4'(cnt);
    @(negedge clk);
    rsp_valid = 0;
    check(out_valid && out_desc == parked[tag] && out_result == r, "R6 release by tag", out_desc, parked[tag]);
    check(!inst_valid, "R8 no install on header", inst_valid, 0);
    for (int i = 0; i < cnt; i++) begin
      check(!rsp_ready, "R7 header blocked while group pending", rsp_ready, 0);
      ent_valid = 1; ent_data = base + EW'(i);
      @(negedge clk);
      ent_valid = 0;
      check(inst_valid && inst_data == base + EW'(i), "R7 install beat", inst_data, base + EW'(i));
    end
    check(rsp_ready, "R7 header ready after group", rsp_ready, 1);
  endtask

  task automatic wait_offset(input int off);
    while (bcyc % WIN != off) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!out_valid && !rd_valid && !inst_valid && !dl_req, "R1 outputs idle",
          {out_valid, rd_valid, inst_valid, dl_req}, 0);
    check(in_ready && rsp_ready, "R1 ready after reset", {in_ready, rsp_ready}, 2'b11);
  endtask

  task automatic t_hits();
    send_hit(32'hA000_0001, 16'h0011);
    send_hit(32'hA000_0002, 16'h0022);
  endtask

  task automatic t_misses_and_replies();
    send_miss(32'hB000_0000, 0, 0, 0);
    send_miss(32'hB000_0001, 1, 1, 0);
    send_miss(32'hB000_0002, 2, 0, 0);
    send_miss(32'hB000_0003, 3, 1, 0);
    in_valid = 1; in_hit = 0;
    #1 check(!in_ready, "R5 miss blocked when tags exhausted", in_ready, 0);
    in_hit = 1;
    #1 check(in_ready, "R5 hit still accepted", in_ready, 1);
    in_valid = 0; in_hit = 0;
    send_rsp(2, 16'h0202, 0, '0);
    send_rsp(0, 16'h0100, 3, 48'h1000);
    send_rsp(3, 16'h0303, 1, 48'h3000);
    send_rsp(1, 16'h0101, 0, '0);
  endtask

  task automatic t_availability();
    bak_up = 0;
    send_miss(32'hC000_0000, 0, 0, 0);
    send_miss(32'hC000_0001, 1, 0, 0);
    pri_up = 0; bak_up = 1;
    send_miss(32'hC000_0002, 2, 1, 0);
    pri_up = 1;
    send_rsp(1, 16'h0C01, 0, '0);
    send_rsp(0, 16'h0C00, 0, '0);
    send_rsp(2, 16'h0C02, 0, '0);
  endtask

  task automatic t_stray_entry();
    ent_valid = 1; ent_data = 48'hDEAD;
    @(negedge clk);
    ent_valid = 0;
    check(!inst_valid, "R10 stray entry ignored", inst_valid, 0);
    @(negedge clk);
    check(!inst_valid, "R10 no late install", inst_valid, 0);
  endtask

  task automatic t_threshold();
    miss_limit = 8'd2;
    wait_offset(0);
    send_miss(32'hD000_0000, 0, 0, 0);
    send_miss(32'hD000_0001, 1, 1, 0);
    send_miss(32'hD000_0002, 2, 0, 1);
    @(negedge clk);
    check(!dl_req, "R11 request lasts one cycle", dl_req, 0);
    send_rsp(0, 16'h0D00, 0, '0);
    send_rsp(1, 16'h0D01, 0, '0);
    send_rsp(2, 16'h0D02, 0, '0);
  endtask

  task automatic t_window_reset();
    wait_offset(WIN - 3);
    send_miss(32'hE000_0000, 0, 1, 0);
    send_miss(32'hE000_0001, 1, 0, 0);
    @(negedge clk);
    send_miss(32'hE000_0002, 2, 1, 0);
    check(bcyc % WIN == 1, "R12 third miss placed in new window", bcyc % WIN, 1);
    send_rsp(0, 16'h0E00, 0, '0);
    send_rsp(1, 16'h0E01, 0, '0);
    send_rsp(2, 16'h0E02, 0, '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_misses_and_replies();
    t_availability();
    t_stray_entry();
    t_threshold();
    t_window_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule